// File: doc/BRIEF.md
# Chained Value Remap Stage

This block sits on the read side of a byte-wide FIFO and corrects each value as it leaves. It keeps a mapping table with one entry per possible data value. A cleared table maps every value to itself, so values pass through unchanged. A change request "turn every A into B" writes B into the entry for A. The FIFO contents are never touched. The correction is applied lazily when a value is read out.

Changes can build on each other. Suppose 5 becomes 6 and 6 later becomes 7. The walker then looks the value up again and again, following the chain until a lookup returns its own argument, and only then presents the result.

Short chains finish well inside the slot between FIFO reads. A long chain raises a stall, and upstream logic holds its data for that time. A cyclic set of changes would never settle, so the number of lookups is capped. When the cap is reached, the result is flagged.

Change requests pass through a small queue. They are applied only while no value is being resolved, so a value in flight always sees one consistent table.

Top module: `remap_resolver`

## Requirements
- R1: While `rst_n` is low, `ready`, `in_ready`, `chg_ready`, `out_valid` and `stall` are low. After `rst_n` rises there is a two-stage reset release, then the table is swept to identity one entry per cycle. `ready` first reads high exactly 2^DATA_W + 2 clock edges after the release and stays high until the next reset.
- R2: A value whose table entry holds itself is output unchanged, with `out_valid` high one clock edge after the edge that accepted it.
- R3: A change from A to B makes later lookups of A return B. Resolution repeats the lookup on each result until a fixed point is reached. For a chain of depth d (d changes to follow), the result appears d+1 edges after acceptance. A change from A to A restores identity for A.
- R4: `stall` is high while a value is being resolved and STALL_AFTER lookups have already been done without reaching a fixed point. It is low whenever `out_valid` is high. With STALL_AFTER = 3, chains of depth 2 or less never raise it, and chains of depth 3 or more do.
- R5: If MAX_LOOKUPS lookups pass without a fixed point, the result of the last lookup is output with `out_capped` high, MAX_LOOKUPS edges after acceptance. A fixed point found on exactly the MAX_LOOKUPS-th lookup is output with `out_capped` low. `out_capped` is never high without `out_valid`.
- R6: Accepted changes are applied to the table one per cycle, oldest first, only while no value is being resolved. `in_ready` is low while the block is not ready, while a value is being resolved, or while changes are still queued.
- R7: A change accepted while a value is being resolved has no effect on that value's result. It takes effect for values accepted after that result is output.
- R8: `chg_ready` is low while CHG_DEPTH changes are queued. A change offered while `chg_ready` is low is dropped and never reaches the table.
- R9: `out_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready | output | 1 | Identity sweep of the table has finished |
| in_valid | input | 1 | A FIFO value is presented |
| in_data | input | DATA_W | Value read from the FIFO |
| in_ready | output | 1 | Value is accepted on this edge when `in_valid` is high |
| chg_valid | input | 1 | A change request is presented |
| chg_from | input | DATA_W | Value to be replaced (table index) |
| chg_to | input | DATA_W | Replacement value |
| chg_ready | output | 1 | Change queue has room |
| out_valid | output | 1 | Corrected value is valid this cycle |
| out_data | output | DATA_W | Corrected value |
| out_capped | output | 1 | Lookup cap was reached for this value |
| stall | output | 1 | Resolution has run past its budget; hold incoming data |

## Verification
The bench keeps the full 8-bit width, so the complete 256-entry sweep and an identity pass over every value are covered. It lowers MAX_LOOKUPS to 6, which makes a two-value cycle and a depth-5 chain hit the cap boundary from both sides in a few cycles. It keeps STALL_AFTER at 3, so the depth-2 and depth-3 boundary for `stall` is exercised directly. CHG_DEPTH is 2, so the queue fills during one long resolution and a change offered while it is full can be shown to be dropped.

// File: rtl/remap_pkg.sv
package remap_pkg;
  // walker control states
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_BUSY = 1'b1
  } walk_state_e;
endpackage

// File: rtl/remap_table.sv
// Mapping storage: one entry per data value, swept to identity after reset.
module remap_table #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              init_done,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ENTRIES = 1 << DATA_W;
  localparam logic [DATA_W-1:0] IDX_LAST = {DATA_W{1'b1}};

  logic [DATA_W-1:0] map_mem [ENTRIES];

  logic              sweep_busy_q, sweep_busy_d;
  logic [DATA_W-1:0] sweep_idx_q, sweep_idx_d;

  logic              mem_we;
  logic [DATA_W-1:0] mem_waddr, mem_wdata;

  always_comb begin
    sweep_busy_d = sweep_busy_q;
    sweep_idx_d  = sweep_idx_q;
    if (sweep_busy_q) begin
      sweep_idx_d = sweep_idx_q + 1'b1;
      if (sweep_idx_q == IDX_LAST) begin
        sweep_busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_busy_q <= 1'b1;
      sweep_idx_q  <= '0;
    end else begin
      sweep_busy_q <= sweep_busy_d;
      sweep_idx_q  <= sweep_idx_d;
    end
  end

  // sweep has priority; the change path is only enabled once ready
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = wr_addr;
    mem_wdata = wr_data;
    if (sweep_busy_q) begin
      mem_we    = 1'b1;
      mem_waddr = sweep_idx_q;
      mem_wdata = sweep_idx_q;
    end else if (wr_en) begin
      mem_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) begin
      map_mem[mem_waddr] <= mem_wdata;
    end
  end

  assign rd_data   = map_mem[rd_addr];
  assign init_done = !sweep_busy_q;
endmodule

// File: rtl/remap_chg_queue.sv
// Small in-order queue of pending change requests.
module remap_chg_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_from,
  input  logic [DATA_W-1:0] push_to,
  input  logic              pop,
  output logic              full,
  output logic              empty,
  output logic [DATA_W-1:0] head_from,
  output logic [DATA_W-1:0] head_to
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] from_mem [DEPTH];
  logic [DATA_W-1:0] to_mem   [DEPTH];

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;

  assign full      = (count_q == CNT_FULL);
  assign empty     = (count_q == '0);
  assign head_from = from_mem[rd_ptr_q];
  assign head_to   = to_mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop) begin
      rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      from_mem[wr_ptr_q] <= push_from;
      to_mem[wr_ptr_q]   <= push_to;
    end
  end
endmodule

// File: rtl/remap_walker.sv
// Follows the mapping chain of one value until it reaches a fixed point or the cap.
module remap_walker
  import remap_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MAX_LOOKUPS = 8,
  parameter int STALL_AFTER = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  output logic [DATA_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              stall,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_capped
);
  localparam int LK_W = $clog2(MAX_LOOKUPS + 1);
  localparam logic [LK_W-1:0] LK_CAP   = LK_W'(MAX_LOOKUPS);
  localparam logic [LK_W-1:0] LK_STALL = LK_W'(STALL_AFTER);

  walk_state_e       state_q, state_d;
  logic [DATA_W-1:0] cur_q, cur_d;
  logic [LK_W-1:0]   lookups_q, lookups_d, lookups_inc;
  logic              ov_q, ov_d, oc_q, oc_d;
  logic [DATA_W-1:0] od_q, od_d;

  assign lookups_inc = lookups_q + 1'b1;

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    lookups_d = lookups_q;
    ov_d      = 1'b0;
    oc_d      = 1'b0;
    od_d      = od_q;
    case (state_q)
      WALK_IDLE: begin
        if (start) begin
          state_d   = WALK_BUSY;
          cur_d     = start_data;
          lookups_d = '0;
        end
      end
      WALK_BUSY: begin
        if (rd_data == cur_q) begin
          state_d = WALK_IDLE;
          ov_d    = 1'b1;
          od_d    = cur_q;
        end else if (lookups_inc == LK_CAP) begin
          state_d = WALK_IDLE;
          ov_d    = 1'b1;
          oc_d    = 1'b1;
          od_d    = rd_data;
        end else begin
          cur_d     = rd_data;
          lookups_d = lookups_inc;
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WALK_IDLE;
      cur_q     <= '0;
      lookups_q <= '0;
      ov_q      <= 1'b0;
      oc_q      <= 1'b0;
      od_q      <= '0;
    end else begin
      state_q   <= state_d;
      cur_q     <= cur_d;
      lookups_q <= lookups_d;
      ov_q      <= ov_d;
      oc_q      <= oc_d;
      od_q      <= od_d;
    end
  end

  assign rd_addr    = cur_q;
  assign busy       = (state_q == WALK_BUSY);
  assign stall      = busy && (lookups_q >= LK_STALL);
  assign out_valid  = ov_q;
  assign out_data   = od_q;
  assign out_capped = oc_q;
endmodule

// File: rtl/remap_resolver.sv
// Top: read-side correction stage with chained lookup resolution.
module remap_resolver #(
  parameter int DATA_W      = 8,
  parameter int MAX_LOOKUPS = 8,
  parameter int STALL_AFTER = 3,
  parameter int CHG_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              ready,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              chg_valid,
  input  logic [DATA_W-1:0] chg_from,
  input  logic [DATA_W-1:0] chg_to,
  output logic              chg_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_capped,
  output logic              stall
);
  logic rst_s1_q, rst_s2_q, rst_int_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  logic              tbl_ready, tbl_we;
  logic [DATA_W-1:0] tbl_raddr, tbl_rdata;
  logic              q_full, q_empty, q_push;
  logic [DATA_W-1:0] q_from, q_to;
  logic              walk_busy, walk_start;

  assign ready      = tbl_ready && rst_int_n;
  assign chg_ready  = rst_int_n && !q_full;
  assign q_push     = chg_valid && chg_ready;
  assign tbl_we     = ready && !walk_busy && !q_empty;
  assign in_ready   = ready && !walk_busy && q_empty;
  assign walk_start = in_valid && in_ready;

  remap_table #(
    .DATA_W (DATA_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .init_done (tbl_ready),
    .wr_en     (tbl_we),
    .wr_addr   (q_from),
    .wr_data   (q_to),
    .rd_addr   (tbl_raddr),
    .rd_data   (tbl_rdata)
  );

  remap_chg_queue #(
    .DATA_W (DATA_W),
    .DEPTH  (CHG_DEPTH)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (q_push),
    .push_from (chg_from),
    .push_to   (chg_to),
    .pop       (tbl_we),
    .full      (q_full),
    .empty     (q_empty),
    .head_from (q_from),
    .head_to   (q_to)
  );

  remap_walker #(
    .DATA_W      (DATA_W),
    .MAX_LOOKUPS (MAX_LOOKUPS),
    .STALL_AFTER (STALL_AFTER)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (walk_start),
    .start_data (in_data),
    .rd_addr    (tbl_raddr),
    .rd_data    (tbl_rdata),
    .busy       (walk_busy),
    .stall      (stall),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_capped (out_capped)
  );
endmodule

// File: rtl/remap_resolver_chk.sv
// Temporal checks for remap_resolver, attached by bind.
module remap_resolver_chk (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_capped,
  input logic stall,
  input logic tbl_we,
  input logic walk_busy
);
  assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  assert_in_needs_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> ready);

  assert_accept_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_out_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_stall_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !stall);

  assert_stall_holds_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !in_ready);

  assert_capped_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_capped |-> out_valid);

  assert_table_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |-> !tbl_we);
endmodule

bind remap_resolver remap_resolver_chk i_remap_resolver_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_capped (out_capped),
  .stall      (stall),
  .tbl_we     (tbl_we),
  .walk_busy  (walk_busy)
);

// File: tb/test_remap_resolver.sv
module test_remap_resolver;
  localparam int DW      = 8;
  localparam int ENTRIES = 1 << DW;
  localparam int MAXLK   = 6;
  localparam int STALLA  = 3;
  localparam int QDEPTH  = 2;

  logic          clk, rst_n;
  logic          ready, in_valid, in_ready, chg_valid, chg_ready;
  logic          out_valid, out_capped, stall;
  logic [DW-1:0] in_data, chg_from, chg_to, out_data;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  remap_resolver #(
    .DATA_W (DW), .MAX_LOOKUPS (MAXLK), .STALL_AFTER (STALLA), .CHG_DEPTH (QDEPTH)
  ) i_remap_resolver (
    .clk (clk), .rst_n (rst_n), .ready (ready),
    .in_valid (in_valid), .in_data (in_data), .in_ready (in_ready),
    .chg_valid (chg_valid), .chg_from (chg_from), .chg_to (chg_to), .chg_ready (chg_ready),
    .out_valid (out_valid), .out_data (out_data), .out_capped (out_capped), .stall (stall)
  );

  initial clk = 1'b0;
  always #2.5ns clk = ~clk;

  typedef struct packed {
    logic          chg;
    logic [DW-1:0] from;
    logic [DW-1:0] to;
    logic [DW-1:0] din;
    logic [DW-1:0] dexp;
    logic [3:0]    lat;
    logic          cap;
    logic          stl;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 8'h00, 8'h11, 8'h11, 4'd1, 1'b0, 1'b0}, // R2 untouched value
    '{1'b1, 8'h05, 8'h06, 8'h05, 8'h06, 4'd2, 1'b0, 1'b0}, // R3 depth 1
    '{1'b1, 8'h06, 8'h07, 8'h05, 8'h07, 4'd3, 1'b0, 1'b0}, // R3 R4 depth 2, no stall
    '{1'b0, 8'h00, 8'h00, 8'h06, 8'h07, 4'd2, 1'b0, 1'b0}, // R3 mid-chain entry
    '{1'b1, 8'h07, 8'h08, 8'h05, 8'h08, 4'd4, 1'b0, 1'b1}, // R4 depth 3 stalls
    '{1'b1, 8'h20, 8'h21, 8'hFF, 8'hFF, 4'd1, 1'b0, 1'b0}, // R2 unrelated change
    '{1'b1, 8'h08, 8'h08, 8'h05, 8'h08, 4'd4, 1'b0, 1'b1}, // R3 self-map change
    '{1'b1, 8'h40, 8'h41, 8'h41, 8'h41, 4'd1, 1'b0, 1'b0}, // R2 target is identity
    '{1'b1, 8'h41, 8'h40, 8'h40, 8'h40, 4'd6, 1'b1, 1'b1}, // R5 cyclic pair capped
    '{1'b1, 8'h41, 8'h41, 8'h40, 8'h41, 4'd2, 1'b0, 1'b0}, // R3 cycle broken
    '{1'b1, 8'h08, 8'h09, 8'h09, 8'h09, 4'd1, 1'b0, 1'b0}, // R2
    '{1'b1, 8'h09, 8'h0A, 8'h05, 8'h0A, 4'd6, 1'b0, 1'b1}, // R5 fixed point on last lookup
    '{1'b1, 8'h0A, 8'h0B, 8'h05, 8'h0B, 4'd6, 1'b1, 1'b1}  // R5 cap one short
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic send_change(input logic [DW-1:0] f, input logic [DW-1:0] t);
    for (int g = 0; g < 100 && !chg_ready; g++) @(negedge clk);
    chg_valid = 1'b1; chg_from = f; chg_to = t;
    @(posedge clk); @(negedge clk);
    chg_valid = 1'b0;
  endtask

  task automatic wait_in_ready();
    for (int g = 0; g < 100 && !in_ready; g++) @(negedge clk);
  endtask

  // push one value and measure result, latency, cap flag, stall
  task automatic push_value(input logic [DW-1:0] v, output logic [DW-1:0] d,
                            output int lat, output bit cap, output bit st);
    wait_in_ready();
    in_valid = 1'b1; in_data = v;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    lat = 0; st = 0; d = '0; cap = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (stall) st = 1;
      if (out_valid) begin
        d = out_data; cap = out_capped;
        break;
      end
    end
  endtask

  initial begin
    #1ms;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    int lat, cnt;
    bit cap, st;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    chg_valid = 1'b0; chg_from = '0; chg_to = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "ready in reset", ready, 0);
    check("R1", "in_ready in reset", in_ready, 0);
    check("R1", "chg_ready in reset", chg_ready, 0);
    check("R1", "out_valid in reset", out_valid, 0);
    check("R1", "stall in reset", stall, 0);
    rst_n = 1'b1;
    cnt = 0;
    for (int k = 0; k < 1000; k++) begin
      @(posedge clk); @(negedge clk);
      cnt++;
      if (ready) break;
    end
    check("R1", "sweep length", cnt, ENTRIES + 2);

    // R1 R2: every value maps to itself after the sweep
    for (int v = 0; v < ENTRIES; v++) begin
      push_value(DW'(v), d, lat, cap, st);
      check("R2", "identity data", d, v);
      check("R2", "identity latency", lat, 1);
    end

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].chg) send_change(VECS[i].from, VECS[i].to);
      push_value(VECS[i].din, d, lat, cap, st);
      check("R3", $sformatf("vec %0d data", i), d, VECS[i].dexp);
      check("R3", $sformatf("vec %0d latency", i), lat, VECS[i].lat);
      check("R5", $sformatf("vec %0d capped", i), cap, VECS[i].cap);
      check("R4", $sformatf("vec %0d stall", i), st, VECS[i].stl);
    end

    // R7 R8: changes during a capped resolution of 5 (chain 5..0B)
    wait_in_ready();
    in_valid = 1'b1; in_data = 8'h05;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chg_valid = 1'b1; chg_from = 8'h05; chg_to = 8'h30;
    lat = 0; d = '0; cap = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (k == 0) begin
        check("R6", "in_ready while resolving", in_ready, 0);
        chg_from = 8'h31; chg_to = 8'h32;
      end
      if (k == 1) begin
        check("R8", "chg_ready when full", chg_ready, 0);
        chg_from = 8'h50; chg_to = 8'h51;
      end
      if (k == 2) chg_valid = 1'b0;
      if (out_valid) begin
        d = out_data; cap = out_capped;
        break;
      end
    end
    chg_valid = 1'b0;
    check("R7", "in-flight data unaffected", d, 8'h0B);
    check("R7", "in-flight latency", lat, MAXLK);
    check("R5", "in-flight capped", cap, 1);
    push_value(8'h05, d, lat, cap, st);
    check("R7", "queued change applied", d, 8'h30);
    check("R7", "queued change latency", lat, 2);
    push_value(8'h31, d, lat, cap, st);
    check("R6", "second queued change applied", d, 8'h32);
    push_value(8'h50, d, lat, cap, st);
    check("R8", "dropped change ignored", d, 8'h50);
    check("R8", "dropped change latency", lat, 1);
    check("R9", "out_valid pulse ends", out_valid, 1);
    @(posedge clk); @(negedge clk);
    check("R9", "out_valid low next cycle", out_valid, 0);
    finish_run();
  end
endmodule